// File: doc/BRIEF.md
# Hybrid Karatsuba Binary Field Multiplier

This block multiplies two elements of the binary extension field GF(2^m) in polynomial basis and returns their product reduced modulo a fixed irreducible polynomial. The carry-less product is built by a recursive Karatsuba-Ofman tree. Each level splits an operand into a lower part of ceil(n/2) bits and an upper part of floor(n/2) bits. It forms three sub-products (low by low, high by high, and the XOR-sum of the halves by the XOR-sum of the halves) and merges them with XOR. Once a sub-operand is no wider than a threshold, a schoolbook AND/XOR array computes that leaf.

The unreduced product of 2m-1 bits can be held in an optional pipeline register right after the combine stage. It is then folded back below degree m by a reduction network and captured in a registered output. The field size, the threshold, the polynomial taps and the pipeline option are parameters, so the same source serves a 233-bit trinomial field, a 163-bit pentanomial field and small configurations for exhaustive checking.

Top module: `gf2m_hk_mul`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and `prod` to zero on the next clock edge.
- R2: `out_valid` rises exactly 1 + PIPE_COMBINE clock edges after the edge that samples `in_valid` high, and stays low otherwise.
- R3: For any operands, `prod` equals a·b reduced modulo P(x) = x^M + Σ taps. Bit i of POLY_TAPS (i < M) is the coefficient of x^i, and bit i of an operand or result is the coefficient of x^i.
- R4: If either operand is zero, the result is zero.
- R5: With `a` equal to the field element 1 (only bit 0 set), the result equals `b`.
- R6: All-ones operands produce the correctly reduced product, which exercises every carry-less partial product term.
- R7: While `out_valid` is low, `prod` keeps its previous value, whatever the operand inputs do.
- R8: With M=163 and taps at bits 7, 6, 3 and 0 (a pentanomial), the results are correct just as in the trinomial default, where M=233 and the taps are at bits 74 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `a`/`b` are valid this cycle |
| a | input | M | First field operand |
| b | input | M | Second field operand |
| out_valid | output | 1 | `prod` carries a new result |
| prod | output | M | Reduced product, registered |

## Verification
A wrong split width or a misplaced middle term in any Karatsuba node corrupts coefficients of the product. The error shows on `prod` in the same result cycle for almost any pair of operands, and the all-ones operands hit every term. A missing or wrongly placed reduction tap shows up only when the unreduced product reaches degree M or more, so random and all-ones operands in wide fields expose it at once. The 7-bit field swept over all operand pairs checks every recursion level fully. A slip in the valid pipeline makes `out_valid` a cycle early or late, which the very first result reveals.

// File: rtl/gf2m_hk_pkg.sv
package gf2m_hk_pkg;
  // Width of the polynomial tap parameter; bounds the supported field size.
  localparam int TAPS_W = 256;
  typedef logic [TAPS_W-1:0] taps_t;

  // Default reduction taps: x^233 + x^74 + 1 (x^M term implied).
  localparam taps_t TRI233_TAPS  = (taps_t'(1) << 74) | taps_t'(1);
  // x^163 + x^7 + x^6 + x^3 + 1.
  localparam taps_t PENT163_TAPS = taps_t'(8'hC9);

  // Lower split keeps the extra bit of an odd width.
  function automatic int lo_width(input int n);
    return (n + 1) / 2;
  endfunction

  function automatic int hi_width(input int n);
    return n / 2;
  endfunction
endpackage

// File: rtl/gf2m_school_mul.sv
module gf2m_school_mul #(
  parameter int W = 8
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-2:0] z
);
  // Plain carry-less array: every x[i]&y[j] lands on coefficient i+j.
  always_comb begin
    z = '0;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        z[i+j] = z[i+j] ^ (x[i] & y[j]);
      end
    end
  end
endmodule

// File: rtl/gf2m_kara_node.sv
module gf2m_kara_node #(
  parameter int W      = 16,
  parameter int THRESH = 11
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-2:0] z
);
  import gf2m_hk_pkg::*;

  if (W <= THRESH || W < 2) begin : g_leaf
    gf2m_school_mul #(.W(W)) i_leaf (.x(x), .y(y), .z(z));
  end else begin : g_split
    localparam int LW = lo_width(W);
    localparam int HW = hi_width(W);
    localparam int PW = 2 * W - 1;
    localparam int LP = 2 * LW - 1;
    localparam int HP = 2 * HW - 1;

    logic [LW-1:0] x_lo, y_lo, x_sum, y_sum;
    logic [HW-1:0] x_hi, y_hi;
    logic [LP-1:0] p_lo, p_sum, p_mid;
    logic [HP-1:0] p_hi;

    assign x_lo  = x[LW-1:0];
    assign y_lo  = y[LW-1:0];
    assign x_hi  = x[W-1:LW];
    assign y_hi  = y[W-1:LW];
    assign x_sum = x_lo ^ LW'(x_hi);
    assign y_sum = y_lo ^ LW'(y_hi);

    gf2m_kara_node #(.W(LW), .THRESH(THRESH)) i_lo  (.x(x_lo),  .y(y_lo),  .z(p_lo));
    gf2m_kara_node #(.W(HW), .THRESH(THRESH)) i_hi  (.x(x_hi),  .y(y_hi),  .z(p_hi));
    gf2m_kara_node #(.W(LW), .THRESH(THRESH)) i_sum (.x(x_sum), .y(y_sum), .z(p_sum));

    // Middle term: (lo+hi)(lo+hi) - lo*lo - hi*hi, all additions XOR.
    assign p_mid = p_sum ^ p_lo ^ LP'(p_hi);

    assign z = PW'(p_lo) ^ (PW'(p_mid) << LW) ^ (PW'(p_hi) << (2 * LW));
  end
endmodule

// File: rtl/gf2m_reduce.sv
module gf2m_reduce #(
  parameter int M = 233,
  parameter logic [M-1:0] POLY = '0
) (
  input  logic [2*M-2:0] full,
  output logic [M-1:0]   red
);
  logic [2*M-2:0] acc;

  // Fold from the top coefficient down; each set bit at degree i >= M
  // is replaced by the tap pattern shifted to degree i-M.
  always_comb begin
    acc = full;
    for (int i = 2 * M - 2; i >= M; i--) begin
      if (acc[i]) begin
        acc[i]         = 1'b0;
        acc[i-M +: M]  = acc[i-M +: M] ^ POLY;
      end
    end
    red = acc[M-1:0];
  end
endmodule

// File: rtl/gf2m_hk_mul.sv
module gf2m_hk_mul #(
  parameter int M = 233,
  parameter int THRESH = 11,
  parameter gf2m_hk_pkg::taps_t POLY_TAPS = gf2m_hk_pkg::TRI233_TAPS,
  parameter int PIPE_COMBINE = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic         out_valid,
  output logic [M-1:0] prod
);
  localparam int PW = 2 * M - 1;
  localparam logic [M-1:0] POLY = POLY_TAPS[M-1:0];

  logic [PW-1:0] full_c;
  logic [PW-1:0] full_s;
  logic          vld_s;
  logic [M-1:0]  red_c;

  gf2m_kara_node #(.W(M), .THRESH(THRESH)) i_tree (.x(a), .y(b), .z(full_c));

  if (PIPE_COMBINE != 0) begin : g_pipe
    logic [PW-1:0] full_q;
    logic          vld_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        full_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) full_q <= full_c;
      end
    end
    assign full_s = full_q;
    assign vld_s  = vld_q;
  end else begin : g_nopipe
    assign full_s = full_c;
    assign vld_s  = in_valid;
  end

  gf2m_reduce #(.M(M), .POLY(POLY)) i_red (.full(full_s), .red(red_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      prod      <= '0;
    end else begin
      out_valid <= vld_s;
      if (vld_s) prod <= red_c;
    end
  end
endmodule

// File: rtl/gf2m_hk_mul_chk.sv
module gf2m_hk_mul_chk #(
  parameter int M = 233,
  parameter int THRESH = 11,
  parameter gf2m_hk_pkg::taps_t POLY_TAPS = gf2m_hk_pkg::TRI233_TAPS,
  parameter int PIPE_COMBINE = 1
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [M-1:0] a,
  input logic [M-1:0] b,
  input logic         out_valid,
  input logic [M-1:0] prod
);
  localparam int LAT = (PIPE_COMBINE != 0) ? 2 : 1;
  localparam logic [M-1:0] ONE = M'(1);

  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (rst) since <= '0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && prod == '0));

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    (int'(since) >= LAT) |-> (out_valid == $past(in_valid, LAT)));

  a_r4_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (int'(since) >= LAT && out_valid && ($past(a, LAT) == '0 || $past(b, LAT) == '0))
      |-> (prod == '0));

  a_r5_identity: assert property (@(posedge clk) disable iff (rst)
    (int'(since) >= LAT && out_valid && $past(a, LAT) == ONE) |-> (prod == $past(b, LAT)));

  a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(prod));
endmodule

bind gf2m_hk_mul gf2m_hk_mul_chk #(
  .M(M), .THRESH(THRESH), .POLY_TAPS(POLY_TAPS), .PIPE_COMBINE(PIPE_COMBINE)
) i_chk (.*);

// File: tb/test_gf2m_hk_mul.sv
module test_gf2m_hk_mul;
  import gf2m_hk_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Small exhaustive field: x^7 + x + 1, no combine register.
  logic         s_iv, s_ov;
  logic [6:0]   s_a, s_b, s_p;
  // Default trinomial field, combine register on.
  logic         t_iv, t_ov;
  logic [232:0] t_a, t_b, t_p;
  // Pentanomial field, combine register on.
  logic         p_iv, p_ov;
  logic [162:0] p_a, p_b, p_p;

  gf2m_hk_mul #(.M(7), .THRESH(2), .POLY_TAPS(taps_t'(8'h03)), .PIPE_COMBINE(0)) i_gf2m_hk_mul_s (
    .clk(clk), .rst(rst), .in_valid(s_iv), .a(s_a), .b(s_b), .out_valid(s_ov), .prod(s_p));

  gf2m_hk_mul i_gf2m_hk_mul (
    .clk(clk), .rst(rst), .in_valid(t_iv), .a(t_a), .b(t_b), .out_valid(t_ov), .prod(t_p));

  gf2m_hk_mul #(.M(163), .THRESH(11), .POLY_TAPS(PENT163_TAPS), .PIPE_COMBINE(1)) i_gf2m_hk_mul_p (
    .clk(clk), .rst(rst), .in_valid(p_iv), .a(p_a), .b(p_b), .out_valid(p_ov), .prod(p_p));

  // Bit-serial modular multiply, most significant bit of y first.
  function automatic logic [255:0] ref_mul(input logic [255:0] x, input logic [255:0] y,
                                           input logic [255:0] taps, input int m);
    logic [256:0] r;
    r = '0;
    for (int i = m - 1; i >= 0; i--) begin
      r = r << 1;
      if (r[m]) begin
        r[m] = 1'b0;
        r = r ^ {1'b0, taps};
      end
      if (y[i]) r = r ^ {1'b0, x};
    end
    return r[255:0];
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_s(input logic [6:0] x, input logic [6:0] y);
    logic [255:0] exp;
    exp = ref_mul(256'(x), 256'(y), 256'h3, 7);
    @(negedge clk); s_a = x; s_b = y; s_iv = 1'b1;
    @(negedge clk); s_iv = 1'b0;
    check(s_ov == 1'b1, "R2 small latency", 256'(s_ov), 256'd1);
    check(s_p == exp[6:0], "R3 small exhaustive", 256'(s_p), exp);
  endtask

  task automatic run_t(input logic [232:0] x, input logic [232:0] y, input string req);
    logic [255:0] exp;
    exp = ref_mul(256'(x), 256'(y), TRI233_TAPS, 233);
    @(negedge clk); t_a = x; t_b = y; t_iv = 1'b1;
    @(negedge clk); t_iv = 1'b0;
    check(t_ov == 1'b0, "R2 not early", 256'(t_ov), 256'd0);
    @(negedge clk);
    check(t_ov == 1'b1, "R2 valid after two edges", 256'(t_ov), 256'd1);
    check(t_p == exp[232:0], req, 256'(t_p), exp);
  endtask

  task automatic run_p(input logic [162:0] x, input logic [162:0] y, input string req);
    logic [255:0] exp;
    exp = ref_mul(256'(x), 256'(y), PENT163_TAPS, 163);
    @(negedge clk); p_a = x; p_b = y; p_iv = 1'b1;
    @(negedge clk); p_iv = 1'b0;
    @(negedge clk);
    check(p_ov == 1'b1, "R2 pentanomial valid", 256'(p_ov), 256'd1);
    check(p_p == exp[162:0], req, 256'(p_p), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [232:0] held;
    s_iv = 1'b0; s_a = '0; s_b = '0;
    t_iv = 1'b0; t_a = '1; t_b = '1;
    p_iv = 1'b0; p_a = '0; p_b = '0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, even with nonzero operands on the trinomial inputs
    check(s_ov == 1'b0 && s_p == '0, "R1 small reset", 256'(s_p), 256'd0);
    check(t_ov == 1'b0 && t_p == '0, "R1 trinomial reset", 256'(t_p), 256'd0);
    check(p_ov == 1'b0 && p_p == '0, "R1 pentanomial reset", 256'(p_p), 256'd0);

    // R3: every operand pair of the 7-bit field
    for (int i = 0; i < 128; i++) begin
      for (int j = 0; j < 128; j++) run_s(7'(i), 7'(j));
    end

    // R4 / R5 / R6 corners on the default field
    run_t('0, '1, "R4 zero a");
    run_t(233'(rnd256()), '0, "R4 zero b");
    run_t(233'd1, 233'(rnd256()), "R5 identity");
    run_t(233'(rnd256()), 233'd1, "R5 identity swapped");
    run_t('1, '1, "R6 all ones trinomial");
    for (int k = 0; k < 60; k++) run_t(233'(rnd256()), 233'(rnd256()), "R3 random trinomial");

    // R7: inputs toggle with in_valid low, result must hold
    held = t_p;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); t_a = 233'(rnd256()); t_b = 233'(rnd256());
      check(t_ov == 1'b0 && t_p == held, "R7 hold while idle", 256'(t_p), 256'(held));
    end

    // R8: pentanomial field
    run_p('1, '1, "R8 all ones pentanomial");
    run_p(163'd1, 163'(rnd256()), "R8 identity pentanomial");
    for (int k = 0; k < 60; k++) run_p(163'(rnd256()), 163'(rnd256()), "R8 random pentanomial");

    // R1: reset again mid-run clears the held result
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(t_ov == 1'b0 && t_p == '0, "R1 reset after use", 256'(t_p), 256'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule